// File: doc/BRIEF.md
# Standby-Aware Output Port

This block is an output-only parallel port for a small microcontroller. Software writes a byte to one data register on the internal peripheral bus. The block holds that byte in an output latch and presents it to the pads together with a per-pin output enable for an external tristate buffer. A read of the register returns the latch contents and never the pin levels.

The output enable follows the chip's reset and low-power sequence. While reset is asserted the pins float, and the latch is cleared to 0. The pins start to drive when the reset sequencer strobes its mode-byte fetch, so they drive low until software writes a value. The enable then stays on until the next reset.

In sleep mode the pins keep driving. In stop mode they keep driving, unless a pin-state select bit was 1 when the stop mode started. In that case all pins float for the whole stop period. The pins have no pull-up, so a disabled pin floats. When stop mode ends, the pins drive the latch value again, and that value is whatever was last written.

Top module: `ostby_port`

## Requirements
- R1: When `reg_sel` and `reg_wr` are both 1 at a rising clock edge, the latch takes the value of `reg_wdata` at that edge. Without that strobe pair the latch keeps its value. `pin_data[i]` is latch bit i.
- R2: `reg_rdata` always equals the latch contents, whatever the pin enable state.
- R3: While `rst_n` is 0, every bit of `pin_oe` is 0 and the latch is all zeros.
- R4: After reset, `pin_oe` stays all zeros until a clock edge at which `mode_fetch` is 1. From the following cycle all `pin_oe` bits are 1, and the pins drive the latch value, which is 0x00 if no write came first. The enable stays set until the next reset, and further `mode_fetch` pulses change nothing.
- R5: If `stop_float` is 1 in the first cycle that `stop_mode` is 1, all `pin_oe` bits are 0 from that cycle, with no clock delay, until `stop_mode` returns to 0.
- R6: If `stop_float` is 0 in the first cycle of stop mode, the pins keep driving the latch value throughout stop mode.
- R7: While `sleep_mode` is 1, the pin enables and pin data are the same as without it.
- R8: During stop mode, changes of `stop_float` after the first cycle do not change `pin_oe`.
- R9: In the cycle `stop_mode` returns to 0, the enabled pins drive again with the unchanged latch value.
- R10: A write in any mode, including a floating stop mode, updates the latch and the readback, and does not change the enable state.
- R11: A `mode_fetch` pulse while `rst_n` is 0 has no effect: after reset is released, the pins stay floating until a later fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Data register selected on the peripheral bus |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the output latch |
| mode_fetch | input | 1 | Strobe from the reset sequencer when it fetches the mode byte |
| stop_mode | input | 1 | Chip is in stop mode |
| sleep_mode | input | 1 | Chip is in sleep mode |
| stop_float | input | 1 | Pin-state select: 1 floats the pins in stop mode |
| pin_data | output | 8 | Per-pin output data |
| pin_oe | output | 8 | Per-pin output-buffer enable, 1 drives |

## Verification
Assertions check the following on every cycle:
- A latch update follows each write strobe, and the latch holds its value when there is no strobe.
- The enable flag never drops once set, except through reset.
- A mode fetch always leaves the enable set.
- A floating stop period stays floating when `stop_float` changes.
- Outside a floating stop period, all pins drive together once the enable is set.

Some behaviour only the bench scenarios can show:
- The floating state inside reset.
- The low drive right after the fetch.
- A fetch ignored during reset.
- Same-cycle floating on stop entry, and both settings of the pin-state bit.
- Sleep transparency.
- The restored value when stop mode ends.

// File: rtl/ostby_pkg.sv
package ostby_pkg;

    // Control state of the enable sequencer
    typedef struct packed {
        logic enable;     // sticky drive permission, set by mode fetch
        logic in_stop;    // stop_mode seen at the last edge
        logic float_cap;  // pin-state select captured at stop entry
    } ctl_t;

    localparam ctl_t CTL_RESET = '{enable: 1'b0, in_stop: 1'b0, float_cap: 1'b0};

endpackage

// File: rtl/ostby_latch.sv
module ostby_latch #(
    parameter int          WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch_q
);

    logic [WIDTH-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        if (wr_en) begin
            latch_d = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= RESET_VAL;
        end else begin
            latch_q <= latch_d;
        end
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (latch_q == $past(wr_data))); // R1

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(latch_q)); // R1

endmodule

// File: rtl/ostby_enable.sv
module ostby_enable
    import ostby_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_fetch,
    input  logic stop_mode,
    input  logic stop_float,
    output logic drive_en
);

    ctl_t ctl_d;
    ctl_t ctl_q;
    logic float_now;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.in_stop = stop_mode;
        if (mode_fetch) begin
            ctl_d.enable = 1'b1;
        end
        if (stop_mode && !ctl_q.in_stop) begin
            ctl_d.float_cap = stop_float;
        end else if (!stop_mode) begin
            ctl_d.float_cap = 1'b0;
        end
    end

    // In the entry cycle the live select decides; afterwards the captured one
    always_comb begin
        float_now = stop_mode & (ctl_q.in_stop ? ctl_q.float_cap : stop_float);
        drive_en  = ctl_q.enable & ~float_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.enable |=> ctl_q.enable); // R4

    AST_FETCH_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fetch |=> ctl_q.enable); // R4

    AST_FLOAT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && $past(stop_mode) && $past(ctl_q.enable) && !$past(drive_en))
        |-> !drive_en); // R8

endmodule

// File: rtl/ostby_drive.sv
module ostby_drive #(
    parameter int WIDTH = 8
) (
    input  logic             drive_en,
    input  logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] pin_data,
    output logic [WIDTH-1:0] pin_oe
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pin_data[i] = latch_q[i];
        assign pin_oe[i]   = drive_en;
    end

endmodule

// File: rtl/ostby_port.sv
module ostby_port #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic             mode_fetch,
    input  logic             stop_mode,
    input  logic             sleep_mode,
    input  logic             stop_float,
    output logic [WIDTH-1:0] pin_data,
    output logic [WIDTH-1:0] pin_oe
);

    localparam logic [WIDTH-1:0] ALL_ON = '1;

    logic             wr_en;
    logic [WIDTH-1:0] latch_q;
    logic             drive_en;
    logic             sleep_unused;

    assign wr_en        = reg_sel & reg_wr;
    assign sleep_unused = sleep_mode;   // sleep leaves the port untouched
    assign reg_rdata    = latch_q;

    ostby_latch #(.WIDTH(WIDTH), .RESET_VAL('0)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (reg_wdata),
        .latch_q (latch_q)
    );

    ostby_enable u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_fetch (mode_fetch),
        .stop_mode  (stop_mode),
        .stop_float (stop_float),
        .drive_en   (drive_en)
    );

    ostby_drive #(.WIDTH(WIDTH)) u_drive (
        .drive_en (drive_en),
        .latch_q  (latch_q),
        .pin_data (pin_data),
        .pin_oe   (pin_oe)
    );

    AST_ENABLES_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe == '0) || (pin_oe == ALL_ON))); // R4

    AST_DRIVE_OUTSIDE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pin_oe) == ALL_ON && !stop_mode) |-> (pin_oe == ALL_ON)); // R7

endmodule

// File: tb/ostby_port_tb.sv
module ostby_port_tb;

    typedef struct {
        string      tag;
        logic [7:0] oe;
        logic [7:0] data;
        logic [7:0] rdata;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       mode_fetch = 1'b0;
    logic       stop_mode = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       stop_float = 1'b0;
    logic [7:0] pin_data;
    logic [7:0] pin_oe;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t expq[$];
    event smp;

    always #10 clk = ~clk;

    ostby_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mode_fetch (mode_fetch),
        .stop_mode  (stop_mode),
        .sleep_mode (sleep_mode),
        .stop_float (stop_float),
        .pin_data   (pin_data),
        .pin_oe     (pin_oe)
    );

    // Monitor: pops one expected item per sample request and compares
    initial begin
        forever begin
            @(smp);
            while (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (pin_oe !== e.oe || pin_data !== e.data || reg_rdata !== e.rdata) begin
                    errors++;
                    $display("FAIL %s: oe=%h data=%h rdata=%h expected oe=%h data=%h rdata=%h",
                             e.tag, pin_oe, pin_data, reg_rdata, e.oe, e.data, e.rdata);
                end
            end
        end
    end

    task automatic expect_now(input string tag, input logic [7:0] oe,
                              input logic [7:0] data, input logic [7:0] rd);
        exp_t e;
        e.tag = tag; e.oe = oe; e.data = data; e.rdata = rd;
        expq.push_back(e);
        #1;
        -> smp;
        #1;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = v;
        cyc();
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic fetch();
        mode_fetch = 1'b1;
        cyc();
        mode_fetch = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc();
        expect_now("R3 reset floating and cleared", 8'h00, 8'h00, 8'h00);
        wr(8'hFF);                       // write ignored under reset
        expect_now("R3 latch held at zero in reset", 8'h00, 8'h00, 8'h00);
        fetch();                         // fetch ignored under reset
        rst_n = 1'b1;
        cyc(); cyc();
        expect_now("R11 fetch in reset ignored", 8'h00, 8'h00, 8'h00);

        fetch();
        expect_now("R4 drive low after fetch", 8'hFF, 8'h00, 8'h00);

        wr(8'hA5);
        expect_now("R1 R2 write A5", 8'hFF, 8'hA5, 8'hA5);
        reg_sel = 1'b1; cyc(); reg_sel = 1'b0;
        expect_now("R1 select without strobe holds", 8'hFF, 8'hA5, 8'hA5);
        wr(8'h3C);
        expect_now("R1 R2 write 3C", 8'hFF, 8'h3C, 8'h3C);

        sleep_mode = 1'b1; cyc();
        expect_now("R7 sleep keeps drive", 8'hFF, 8'h3C, 8'h3C);
        sleep_mode = 1'b0;

        stop_float = 1'b1; stop_mode = 1'b1;
        expect_now("R5 float in stop entry cycle", 8'h00, 8'h3C, 8'h3C);
        cyc();
        stop_float = 1'b0; cyc();
        expect_now("R8 select drop in stop ignored", 8'h00, 8'h3C, 8'h3C);
        wr(8'h81);
        expect_now("R10 write during floating stop", 8'h00, 8'h81, 8'h81);
        stop_mode = 1'b0;
        expect_now("R9 drive restored on stop exit", 8'hFF, 8'h81, 8'h81);
        cyc();

        stop_mode = 1'b1; cyc();
        expect_now("R6 stop with select 0 drives", 8'hFF, 8'h81, 8'h81);
        stop_float = 1'b1; cyc(); cyc();
        expect_now("R8 select rise in stop ignored", 8'hFF, 8'h81, 8'h81);
        stop_mode = 1'b0; stop_float = 1'b0; cyc();

        fetch();
        expect_now("R4 second fetch no change", 8'hFF, 8'h81, 8'h81);
        wr(8'h5A);
        expect_now("R10 write keeps enable", 8'hFF, 8'h5A, 8'h5A);

        rst_n = 1'b0;
        expect_now("R3 reset mid-run floats", 8'h00, 8'h00, 8'h00);
        cyc();
        rst_n = 1'b1; cyc();
        expect_now("R4 floating again after reset", 8'h00, 8'h00, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule